// File: doc/BRIEF.md
# Byte FIFO with Sectioned Occupancy Level

This block is a byte-wide first-in first-out buffer between a producer and a consumer that share one clock. A write and a read may both be accepted in the same cycle. In place of an exact fill count, the buffer reports a coarse level: how many of its sixteen equal-sized sections hold data. The level is found by subtracting the section-index bits of the read pointer from those of the write pointer.

The producer is expected to stop at a level of sixteen (full). The consumer is expected to stop at a level of zero (empty). Because the level counts whole sections, bytes in a section the writer has not yet left are not readable. Reads release a section only once the read pointer has moved past all of it.

The depth is set by the address width: `ADDR_W = 17` gives 128K bytes in sixteen 8K sections. The default value is smaller so that the storage array stays modest.

Top module: `sect_fifo`

## Requirements
- R1: Bytes leave in the order they were accepted. The byte for an accepted read appears on `rd_data` on the clock edge that accepts the read, so it is visible in the following cycle.
- R2: The level is (W - R) mod 2^(SECT_W+1), in the range 0 to 16. Here W and R are the top SECT_W+1 bits of the write and read pointers, and each pointer is ADDR_W+1 bits wide (the top bit is a wrap bit). A partly written section does not count.
- R3: A write is ignored while the level computed from the current pointers is 16. The buffer never holds more than 2^ADDR_W bytes.
- R4: A read is ignored while the level computed from the current pointers is 0. The read pointer does not move, and `rd_data` holds its previous value.
- R5: `empty` is 1 exactly when `sect_cnt` is 0, and `full` is 1 exactly when `sect_cnt` is 16.
- R6: `sect_cnt`, `empty` and `full` are registered. They show the pointers as they stood one clock earlier, so they change one cycle after a pointer moves.
- R7: When the level is neither 0 nor 16, a write and a read requested in the same cycle are both accepted in that cycle.
- R8: After reset, both pointers are zero, `sect_cnt` is 0, `empty` is 1, `full` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Byte to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Byte from the last accepted read |
| sect_cnt | output | SECT_W+1 | Number of filled sections, 0 to 16 |
| empty | output | 1 | Level is 0 |
| full | output | 1 | Level is 16 |

## Verification
The bench builds the block with `ADDR_W = 6`, which gives a 64-byte buffer of sixteen 4-byte sections. This size lets the bench reach a full buffer, the ignored write at full, the ignored read while a partial section sits unreadable, and pointer wrap-around in a few hundred cycles. The same arithmetic governs the 128K build.

// File: rtl/sect_fifo.sv
module sect_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [SECT_W:0]   sect_cnt,
  output logic              empty,
  output logic              full
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  localparam logic [SECT_W:0] NSECT = (SECT_W+1)'(1 << SECT_W);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr, rptr;
  logic [SECT_W:0]   live_cnt;
  logic              wr_ok, rd_ok;

  assign live_cnt = wptr[PW-1 -: SECT_W+1] - rptr[PW-1 -: SECT_W+1];
  assign wr_ok    = wr_en && (live_cnt != NSECT);
  assign rd_ok    = rd_en && (live_cnt != '0);

  always_ff @(posedge clk)
    if (wr_ok) mem[wptr[ADDR_W-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      rd_data  <= '0;
      sect_cnt <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr[ADDR_W-1:0]];
      end
      sect_cnt <= live_cnt;
      empty    <= (live_cnt == '0);
      full     <= (live_cnt == NSECT);
    end
  end
endmodule

module sect_fifo_chk #(
  parameter int ADDR_W = 10,
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W:0]   wptr,
  input logic [ADDR_W:0]   rptr,
  input logic [SECT_W:0]   sect_cnt,
  input logic              empty,
  input logic              full
);
  localparam logic [ADDR_W:0] DEPTH_P = (ADDR_W+1)'(1 << ADDR_W);
  localparam logic [ADDR_W:0] HALF_P  = (ADDR_W+1)'(1 << (ADDR_W-1));
  localparam logic [SECT_W:0] NSECT   = (SECT_W+1)'(1 << SECT_W);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sect_cnt <= NSECT);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr - rptr) <= DEPTH_P);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wptr == rptr) |=> $stable(rptr));

  assert_flag_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  assert_empty_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr == rptr) |=> empty);

  assert_both_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && (wptr - rptr) == HALF_P) |=>
      (wptr == $past(wptr) + 1'b1 && rptr == $past(rptr) + 1'b1));
endmodule

bind sect_fifo sect_fifo_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .wptr(wptr), .rptr(rptr), .sect_cnt(sect_cnt), .empty(empty), .full(full)
);

// File: tb/test_sect_fifo.sv
module test_sect_fifo;
  localparam int AW = 6;
  localparam int SH = AW - 4;
  localparam int PMOD = 2 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic [4:0] sect_cnt;
  logic empty, full;

  int total = 0, bad = 0;
  int wp = 0, rp = 0;
  logic [7:0] q[$];
  logic [7:0] last_rd = 8'h00;
  logic [7:0] seed = 8'h10;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sect_fifo #(.DATA_W(8), .ADDR_W(AW), .SECT_W(4)) i_sect_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sect_cnt(sect_cnt),
    .empty(empty), .full(full));

  function automatic int lvl();
    return ((wp >> SH) - (rp >> SH)) & 31;
  endfunction

  task automatic check(string rq, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(bit w, bit r);
    int c;
    bit wa, ra;
    logic [7:0] e;
    c  = lvl();
    wa = w && c != 16;
    ra = r && c != 0;
    wr_en = w; rd_en = r; wr_data = seed;
    if (wa) begin q.push_back(seed); wp = (wp + 1) % PMOD; end
    if (w) seed++;
    e = last_rd;
    if (ra) begin e = q.pop_front(); rp = (rp + 1) % PMOD; end
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (r) check(ra ? "R1 data order" : "R4 rd_data holds", rd_data, e);
    last_rd = e;
  endtask

  task automatic settle_check(string rq);
    @(posedge clk); @(negedge clk);
    check({rq, " level"}, sect_cnt, lvl());
    check("R5 empty", empty, lvl() == 0);
    check("R5 full", full, lvl() == 16);
  endtask

  task automatic t_reset();
    check("R8 level", sect_cnt, 0);
    check("R8 empty", empty, 1);
    check("R8 full", full, 0);
    check("R8 rd_data", rd_data, 0);
  endtask

  task automatic t_partial();
    for (int i = 0; i < 3; i++) cyc(1, 0);
    settle_check("R2 partial");
    cyc(0, 1);
    settle_check("R4 read at zero");
    cyc(1, 0);
    check("R6 level before lag", sect_cnt, 0);
    settle_check("R6 level after lag");
    check("R2 one section", sect_cnt, 1);
  endtask

  task automatic t_fill();
    while (lvl() != 16) cyc(1, 0);
    settle_check("R3 at full");
    check("R3 full seen", full, 1);
    cyc(1, 0);
    cyc(1, 0);
    settle_check("R3 write ignored");
    check("R3 count", wp - rp, 64);
  endtask

  task automatic t_both();
    for (int i = 0; i < 4; i++) cyc(0, 1);
    settle_check("R1 after section read");
    check("R7 level 15", sect_cnt, 15);
    for (int i = 0; i < 3; i++) cyc(1, 1);
    settle_check("R7 both");
    check("R7 occupancy kept", (wp - rp + PMOD) % PMOD, 60);
  endtask

  task automatic t_drain();
    while (lvl() != 0) cyc(0, 1);
    settle_check("R4 drained");
    cyc(0, 1);
    settle_check("R4 read ignored");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 23; i++) cyc(1, (i % 3) == 2);
      settle_check("R2 wrap fill");
      for (int i = 0; i < 23; i++) cyc(i % 4 == 0, 1);
      settle_check("R2 wrap drain");
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_partial();
    t_fill();
    t_both();
    t_drain();
    t_wrap();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule